// File: doc/BRIEF.md
# DRAM Initialization Mode Command Sequencer

This block sits between a host access port and a DRAM command port. Software brings a DRAM device out of power-up one step at a time through a 3-bit mode field. In each special mode, every host access is rewritten into a single fixed DRAM command: a no-op, a precharge of all banks, a mode-register load or an auto refresh. In the normal mode, host reads and writes pass through a small in-order queue to the DRAM port with their address unchanged.

The block also drives the DRAM clock enable and CKE. Both stay low from reset until software first writes a non-zero mode. The clock then starts, and CKE follows after a power-up delay that is counted in clock cycles. Once CKE is up, a low-power request level drains the queue and parks the device in self-refresh. Dropping that level brings the device back out without any software action. A full reset puts the mode field back to zero and stops the clock again.

Top module: `dram_init_seq`

## Requirements
- R1: While rst_n is low, dram_clk_en, dram_cke, dram_cmd_vld and sr_active are 0, and the mode field is cleared to 000. A later access is then treated as mode 000.
- R2: After reset, dram_clk_en and dram_cke stay 0 until a mode value other than 000 is written. Writing 000 leaves them at 0.
- R3: The clock enable rises on the edge that samples the first non-zero mode write. dram_cke rises exactly CKE_CYC = ceil(CKE_DLY_PS / CLK_PS) cycles later. dram_cke is never 1 while dram_clk_en is 0, and dram_clk_en stays 1 until reset.
- R4: In modes 001, 010 and 110, each acknowledged access gives exactly one command in the next cycle, with address 0. The command codes are NOP=0 for mode 001, precharge-all=1 for mode 010 and refresh=3 for mode 110.
- R5: In mode 011, each acknowledged access gives one mode-register-set command (code 2) in the next cycle. The DRAM address takes bits [9:0] from host address [12:3] and bit 11 from host address bit 13. Bit 10 and all bits above 11 are 0.
- R6: In mode 111, an access is acknowledged when the queue (QDEPTH entries) is not full. Queued accesses leave in arrival order, one per cycle in which dram_free is 1. Each leaves as read (code 4) or write (code 5) with address host_addr[DA_W-1:0]. The first one appears two cycles after acceptance when dram_free is 1.
- R7: In modes 000, 100 and 101, an access is acknowledged and produces no command.
- R8: An access in modes 001, 010, 011 or 110 is not acknowledged while the queue holds entries.
- R9: When sr_req is 1 with CKE up, host acceptance stops and the queue drains. Then a self-refresh-entry command (code 6) is issued in the same cycle that dram_cke goes to 0 and sr_active goes to 1. No access is acknowledged while sr_active is 1.
- R10: When sr_req returns to 0 in self-refresh, the next cycle carries self-exit (code 7) with dram_cke at 1 and sr_active at 0. Accesses are then accepted in the old mode with no mode write.
- R11: An access presented in a cycle where sr_req is 1 and CKE is up is not acknowledged and never reaches the DRAM port.
- R12: An access presented in the same cycle as a mode write is handled under the mode in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode field write strobe |
| cfg_mode | input | 3 | Mode value to write |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | HA_W | Host access address |
| host_ack | output | 1 | Access accepted this cycle |
| sr_req | input | 1 | Low-power level: 1 requests self-refresh, 0 requests exit |
| dram_free | input | 1 | DRAM port can take a queued command this cycle |
| dram_clk_en | output | 1 | DRAM clock enable |
| dram_cke | output | 1 | DRAM clock-enable pin level |
| dram_cmd_vld | output | 1 | Command valid this cycle |
| dram_cmd | output | 3 | Command code |
| dram_addr | output | DA_W | Command address |
| sr_active | output | 1 | All ranks are in self-refresh |

## Verification
Two pairs of events can land on the same cycle. A host access can arrive in the very cycle that raises the self-refresh request, and a mode write can arrive together with an access. The bench drives the first pair on one falling edge, with two reads still queued. It passes if the access gets no acknowledge, exactly the two queued reads reach the port, and then the entry command appears with CKE low. The bench drives the second pair the same way and passes if the command that comes out belongs to the mode in force before the write.

// File: rtl/dis_pkg.sv
package dis_pkg;

   typedef enum logic [2:0] {
      MD_IDLE = 3'b000,
      MD_NOP  = 3'b001,
      MD_PALL = 3'b010,
      MD_MREG = 3'b011,
      MD_RSV4 = 3'b100,
      MD_RSV5 = 3'b101,
      MD_AREF = 3'b110,
      MD_RUN  = 3'b111
   } mode_e;

   typedef enum logic [2:0] {
      C_NOP  = 3'd0,
      C_PALL = 3'd1,
      C_MREG = 3'd2,
      C_AREF = 3'd3,
      C_RD   = 3'd4,
      C_WR   = 3'd5,
      C_SRIN = 3'd6,
      C_SROUT= 3'd7
   } cmd_e;

   typedef enum logic [1:0] {K_DROP, K_DIRECT, K_QUEUE} kind_e;

   typedef enum logic [1:0] {PW_OFF, PW_WAIT, PW_ON} pwr_e;

   typedef enum logic [1:0] {SR_RUN, SR_DRAIN, SR_SELF} sr_e;

   // delay in cycles, rounded up so it is never short
   function automatic int unsigned ceil_cycles(input int unsigned dly_ps,
                                               input int unsigned clk_ps);
      return (dly_ps + clk_ps - 1) / clk_ps;
   endfunction

endpackage

// File: rtl/dis_pwr_seq.sv
module dis_pwr_seq
   import dis_pkg::*;
#(
   parameter int unsigned CLK_PS     = 5000,
   parameter int unsigned CKE_DLY_PS = 35000
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [2:0] cfg_mode,
   output mode_e      mode_q,
   output logic       clk_en,
   output logic       cke_up
);

   localparam int unsigned CYC = ceil_cycles(CKE_DLY_PS, CLK_PS);
   localparam int unsigned CW  = $clog2(CYC + 1);

   generate
      if (CLK_PS == 0) begin : g_bad_clk
         $error("dis_pwr_seq: CLK_PS must be non-zero");
      end
      if (CYC < 1) begin : g_bad_dly
         $error("dis_pwr_seq: CKE delay must be at least one cycle");
      end
   endgenerate

   pwr_e          st_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MD_IDLE;
      end else if (cfg_we) begin
         mode_q <= mode_e'(cfg_mode);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PW_OFF;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            PW_OFF: begin
               if (cfg_we && (cfg_mode != 3'b000)) begin
                  st_q  <= PW_WAIT;
                  cnt_q <= '0;
               end
            end
            PW_WAIT: begin
               if (cnt_q == CW'(CYC - 1)) begin
                  st_q <= PW_ON;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: st_q <= PW_ON;
         endcase
      end
   end

   assign clk_en = (st_q != PW_OFF);
   assign cke_up = (st_q == PW_ON);

endmodule

// File: rtl/dis_cmd_fifo.sv
module dis_cmd_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 15
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNTW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("dis_cmd_fifo: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]    mem [DEPTH];
   logic [AW-1:0]   wp_q, rp_q;
   logic [CNTW-1:0] cnt_q;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      if (p == AW'(DEPTH - 1)) return '0;
      return p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= bump(wp_q);
         if (pop)  rp_q <= bump(rp_q);
         unique case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = mem[rp_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNTW'(DEPTH));

endmodule

// File: rtl/dis_sr_ctrl.sv
module dis_sr_ctrl
   import dis_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sr_req,
   input  logic cke_up,
   input  logic q_empty,
   output sr_e  state,
   output logic go_in,
   output logic go_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SR_RUN;
      end else begin
         unique case (state)
            SR_RUN:   if (sr_req && cke_up) state <= SR_DRAIN;
            SR_DRAIN: if (q_empty) state <= SR_SELF;
            SR_SELF:  if (!sr_req) state <= SR_RUN;
            default:  state <= SR_RUN;
         endcase
      end
   end

   assign go_in  = (state == SR_DRAIN) && q_empty;
   assign go_out = (state == SR_SELF) && !sr_req;

endmodule

// File: rtl/dis_cmd_map.sv
module dis_cmd_map
   import dis_pkg::*;
#(
   parameter int unsigned HA_W = 16,
   parameter int unsigned DA_W = 14
)(
   input  mode_e            mode,
   input  logic             host_we,
   input  logic [HA_W-1:0]  host_addr,
   output kind_e            kind,
   output cmd_e             cmd,
   output logic [DA_W-1:0]  addr
);

   logic [DA_W-1:0] mreg_addr;
   logic [DA_W-1:0] pass_addr;

   assign mreg_addr[9:0] = host_addr[12:3];
   assign mreg_addr[10]  = 1'b0;
   assign mreg_addr[11]  = host_addr[13];
   assign pass_addr      = host_addr[DA_W-1:0];

   generate
      if (DA_W > 12) begin : g_hi_zero
         assign mreg_addr[DA_W-1:12] = '0;
      end
      if (HA_W > DA_W) begin : g_hi_unused
         logic unused_hi;
         assign unused_hi = ^host_addr[HA_W-1:DA_W];
      end
   endgenerate

   always_comb begin
      kind = K_DIRECT;
      cmd  = C_NOP;
      addr = '0;
      unique case (mode)
         MD_NOP:  cmd = C_NOP;
         MD_PALL: cmd = C_PALL;
         MD_AREF: cmd = C_AREF;
         MD_MREG: begin
            cmd  = C_MREG;
            addr = mreg_addr;
         end
         MD_RUN: begin
            kind = K_QUEUE;
            cmd  = host_we ? C_WR : C_RD;
            addr = pass_addr;
         end
         default: kind = K_DROP;
      endcase
   end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
   import dis_pkg::*;
#(
   parameter int unsigned HA_W       = 16,
   parameter int unsigned DA_W       = 14,
   parameter int unsigned QDEPTH     = 4,
   parameter int unsigned CLK_PS     = 5000,
   parameter int unsigned CKE_DLY_PS = 35000
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [2:0]      cfg_mode,
   input  logic            host_req,
   input  logic            host_we,
   input  logic [HA_W-1:0] host_addr,
   output logic            host_ack,
   input  logic            sr_req,
   input  logic            dram_free,
   output logic            dram_clk_en,
   output logic            dram_cke,
   output logic            dram_cmd_vld,
   output logic [2:0]      dram_cmd,
   output logic [DA_W-1:0] dram_addr,
   output logic            sr_active
);

   localparam int unsigned QW = DA_W + 1;

   generate
      if (DA_W < 12) begin : g_bad_da
         $error("dram_init_seq: DA_W must be at least 12");
      end
      if (HA_W < 14 || HA_W < DA_W) begin : g_bad_ha
         $error("dram_init_seq: HA_W must cover bit 13 and DA_W");
      end
   endgenerate

   mode_e           mode_q;
   logic            cke_up;
   kind_e           map_kind;
   cmd_e            map_cmd;
   logic [DA_W-1:0] map_addr;
   logic            q_empty, q_full, q_push, q_pop;
   logic [QW-1:0]   q_dout;
   sr_e             sr_state;
   logic            go_in, go_out;
   logic            room, accept, direct_hit;

   dis_pwr_seq #(.CLK_PS(CLK_PS), .CKE_DLY_PS(CKE_DLY_PS)) u_pwr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_mode (cfg_mode),
      .mode_q   (mode_q),
      .clk_en   (dram_clk_en),
      .cke_up   (cke_up)
   );

   dis_cmd_map #(.HA_W(HA_W), .DA_W(DA_W)) u_map (
      .mode      (mode_q),
      .host_we   (host_we),
      .host_addr (host_addr),
      .kind      (map_kind),
      .cmd       (map_cmd),
      .addr      (map_addr)
   );

   dis_cmd_fifo #(.DEPTH(QDEPTH), .W(QW)) u_q (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (q_push),
      .din   ({(map_cmd == C_WR), map_addr}),
      .pop   (q_pop),
      .dout  (q_dout),
      .empty (q_empty),
      .full  (q_full)
   );

   dis_sr_ctrl u_sr (
      .clk     (clk),
      .rst_n   (rst_n),
      .sr_req  (sr_req),
      .cke_up  (cke_up),
      .q_empty (q_empty),
      .state   (sr_state),
      .go_in   (go_in),
      .go_out  (go_out)
   );

   always_comb begin
      unique case (map_kind)
         K_QUEUE:  room = !q_full;
         K_DIRECT: room = q_empty;
         default:  room = 1'b1;
      endcase
   end

   assign accept     = (sr_state == SR_RUN) && !(sr_req && cke_up) && room;
   assign host_ack   = host_req && accept;
   assign q_push     = host_ack && (map_kind == K_QUEUE);
   assign q_pop      = dram_free && !q_empty && (sr_state != SR_SELF);
   assign direct_hit = host_ack && (map_kind == K_DIRECT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dram_cmd_vld <= 1'b0;
         dram_cmd     <= C_NOP;
         dram_addr    <= '0;
      end else begin
         dram_cmd_vld <= 1'b0;
         dram_cmd     <= C_NOP;
         dram_addr    <= '0;
         if (go_in) begin
            dram_cmd_vld <= 1'b1;
            dram_cmd     <= C_SRIN;
         end else if (go_out) begin
            dram_cmd_vld <= 1'b1;
            dram_cmd     <= C_SROUT;
         end else if (q_pop) begin
            dram_cmd_vld <= 1'b1;
            dram_cmd     <= q_dout[DA_W] ? C_WR : C_RD;
            dram_addr    <= q_dout[DA_W-1:0];
         end else if (direct_hit) begin
            dram_cmd_vld <= 1'b1;
            dram_cmd     <= map_cmd;
            dram_addr    <= map_addr;
         end
      end
   end

   assign dram_cke  = cke_up && (sr_state != SR_SELF);
   assign sr_active = (sr_state == SR_SELF);

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
   parameter int unsigned DA_W = 14
)(
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      mode_i,
   input logic            host_ack,
   input logic            sr_req,
   input logic            dram_clk_en,
   input logic            dram_cke,
   input logic            dram_cmd_vld,
   input logic [2:0]      dram_cmd,
   input logic [DA_W-1:0] dram_addr,
   input logic            sr_active
);

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!dram_clk_en && !dram_cke && !dram_cmd_vld && !sr_active));

   p_cke_needs_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dram_cke |-> dram_clk_en);

   p_clk_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dram_clk_en |=> dram_clk_en);

   p_nop_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack && mode_i == 3'b001) |=> (dram_cmd_vld && dram_cmd == 3'd0));

   p_ref_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack && mode_i == 3'b110) |=> (dram_cmd_vld && dram_cmd == 3'd3));

   p_mreg_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd_vld && dram_cmd == 3'd2) |->
         (!dram_addr[10] && (dram_addr >> 12) == '0));

   p_srin_cke_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_cmd_vld && dram_cmd == 3'd6) |-> (!dram_cke && sr_active));

   p_no_ack_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sr_active |-> !host_ack);

   p_exit_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sr_active) |-> (dram_cmd_vld && dram_cmd == 3'd7 && dram_cke));

   p_req_blocks_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_req && dram_cke) |-> !host_ack);

endmodule

bind dram_init_seq dram_init_seq_chk #(.DA_W(DA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_i       (mode_q),
   .host_ack     (host_ack),
   .sr_req       (sr_req),
   .dram_clk_en  (dram_clk_en),
   .dram_cke     (dram_cke),
   .dram_cmd_vld (dram_cmd_vld),
   .dram_cmd     (dram_cmd),
   .dram_addr    (dram_addr),
   .sr_active    (sr_active)
);

// File: tb/test_dram_init_seq.sv
module test_dram_init_seq;

   localparam int CLK_PERIOD = 10;
   localparam int HA_W       = 16;
   localparam int DA_W       = 14;
   localparam int QD         = 4;
   localparam int CLK_PS     = 5000;
   localparam int DLY_PS     = 35000;
   localparam int CKE_CYC    = (DLY_PS + CLK_PS - 1) / CLK_PS;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cfg_we;
   logic [2:0]      cfg_mode;
   logic            host_req, host_we;
   logic [HA_W-1:0] host_addr;
   logic            host_ack;
   logic            sr_req, dram_free;
   logic            dram_clk_en, dram_cke, dram_cmd_vld, sr_active;
   logic [2:0]      dram_cmd;
   logic [DA_W-1:0] dram_addr;

   int n_cmp = 0;
   int n_bad = 0;

   dram_init_seq #(.HA_W(HA_W), .DA_W(DA_W), .QDEPTH(QD),
                   .CLK_PS(CLK_PS), .CKE_DLY_PS(DLY_PS)) i_dram_init_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_ack(host_ack), .sr_req(sr_req), .dram_free(dram_free),
      .dram_clk_en(dram_clk_en), .dram_cke(dram_cke),
      .dram_cmd_vld(dram_cmd_vld), .dram_cmd(dram_cmd),
      .dram_addr(dram_addr), .sr_active(sr_active)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   // kind: 0 none, 1 direct, 2 queued
   task automatic expect_for(input int m, input bit we, input logic [HA_W-1:0] a,
                             output int kind, output int cmd, output int addr);
      kind = 1; cmd = 0; addr = 0;
      case (m)
         1: cmd = 0;
         2: cmd = 1;
         6: cmd = 3;
         3: begin
            cmd  = 2;
            addr = ((int'(a) >> 3) & 'h3FF) | (((int'(a) >> 13) & 1) << 11);
         end
         7: begin
            kind = 2;
            cmd  = we ? 5 : 4;
            addr = int'(a) & ((1 << DA_W) - 1);
         end
         default: kind = 0;
      endcase
   endtask

   task automatic set_mode(input int m);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_mode = 3'(m);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_access(input int m, input bit we, input logic [HA_W-1:0] a);
      int kind, cmd, addr;
      string rq;
      expect_for(m, we, a, kind, cmd, addr);
      rq = (kind == 0) ? "R7" : (kind == 2) ? "R6" : (m == 3) ? "R5" : "R4";
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = a;
      #1 chk(rq, "ack", int'(host_ack), 1);
      @(negedge clk);
      host_req = 1'b0;
      if (kind == 2) begin
         chk(rq, "vld before queue exit", int'(dram_cmd_vld), 0);
         @(negedge clk);
      end
      chk(rq, "cmd valid", int'(dram_cmd_vld), (kind == 0) ? 0 : 1);
      if (kind != 0) begin
         chk(rq, "cmd code", int'(dram_cmd), cmd);
         chk(rq, "cmd addr", int'(dram_addr), addr);
      end
   endtask

   initial begin
      int cnt, npop;
      bit seen;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = 3'b000;
      host_req = 1'b0; host_we = 1'b0; host_addr = '0;
      sr_req = 1'b0; dram_free = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "clk_en in reset", int'(dram_clk_en), 0);
      chk("R1", "cke in reset", int'(dram_cke), 0);
      chk("R1", "vld in reset", int'(dram_cmd_vld), 0);
      chk("R1", "sr_active in reset", int'(sr_active), 0);
      rst_n = 1'b1;

      repeat (5) @(negedge clk);
      chk("R2", "clk_en idle", int'(dram_clk_en), 0);
      set_mode(0);
      repeat (3) @(negedge clk);
      chk("R2", "clk_en after 000 write", int'(dram_clk_en), 0);
      chk("R2", "cke after 000 write", int'(dram_cke), 0);
      do_access(0, 1'b0, 16'h1234);

      // power-up delay
      set_mode(1);
      chk("R3", "clk_en after first write", int'(dram_clk_en), 1);
      cnt = 0;
      for (int i = 0; i < 200; i++) begin
         if (dram_cke) break;
         if (dram_clk_en) cnt++;
         @(negedge clk);
      end
      chk("R3", "cycles clock on with cke low", cnt, CKE_CYC);
      chk("R3", "cke up", int'(dram_cke), 1);

      // sweep every mode, both directions, several address patterns
      for (int m = 0; m < 8; m++) begin
         set_mode(m);
         for (int w = 0; w < 2; w++) begin
            for (int p = 0; p < 4; p++) begin
               logic [HA_W-1:0] a;
               case (p)
                  0: a = '0;
                  1: a = '1;
                  2: a = 16'hA5A5 ^ 16'(m << p);
                  default: a = 16'(1 << (3 + p + m));
               endcase
               do_access(m, w[0], a);
            end
         end
      end
      chk("R3", "clk_en held", int'(dram_clk_en), 1);

      // mode write and access in the same cycle
      set_mode(1);
      @(negedge clk);
      cfg_we = 1'b1; cfg_mode = 3'b011;
      host_req = 1'b1; host_we = 1'b0; host_addr = 16'h3FF8;
      #1 chk("R12", "ack with write", int'(host_ack), 1);
      @(negedge clk);
      cfg_we = 1'b0; host_req = 1'b0;
      chk("R12", "old mode cmd", int'(dram_cmd), 0);
      chk("R12", "old mode vld", int'(dram_cmd_vld), 1);
      do_access(3, 1'b0, 16'h3FF8);

      // queue fill, ordering and special-mode hold-off
      set_mode(7);
      dram_free = 1'b0;
      for (int i = 0; i < QD; i++) begin
         @(negedge clk);
         host_req = 1'b1; host_we = i[0]; host_addr = 16'(16'h0100 + i);
         #1 chk("R6", "ack while room", int'(host_ack), 1);
      end
      @(negedge clk);
      host_addr = 16'h0200;
      #1 chk("R6", "ack when full", int'(host_ack), 0);
      host_req = 1'b0;
      set_mode(1);
      @(negedge clk);
      host_req = 1'b1; host_addr = '0;
      #1 chk("R8", "special ack while queued", int'(host_ack), 0);
      dram_free = 1'b1;
      for (int i = 0; i < QD; i++) begin
         @(negedge clk);
         chk("R6", "queued vld", int'(dram_cmd_vld), 1);
         chk("R6", "queued code", int'(dram_cmd), i[0] ? 5 : 4);
         chk("R6", "queued order", int'(dram_addr), 'h100 + i);
         #1 chk("R8", "special ack vs queue", int'(host_ack), (i == QD - 1) ? 1 : 0);
      end
      @(negedge clk);
      host_req = 1'b0;
      chk("R8", "special after drain", int'(dram_cmd), 0);
      chk("R8", "special vld", int'(dram_cmd_vld), 1);

      // self-refresh entry colliding with an access
      set_mode(7);
      dram_free = 1'b0;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         host_req = 1'b1; host_we = 1'b0; host_addr = 16'(16'h0300 + i);
      end
      @(negedge clk);
      host_addr = 16'h03AA; sr_req = 1'b1;
      #1 chk("R11", "ack with sr_req", int'(host_ack), 0);
      host_req = 1'b0; dram_free = 1'b1;
      npop = 0; seen = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (dram_cmd_vld && (dram_cmd == 3'd4 || dram_cmd == 3'd5)) npop++;
         if (dram_cmd_vld && dram_cmd == 3'd6) begin
            seen = 1'b1;
            chk("R9", "cke with entry", int'(dram_cke), 0);
            chk("R9", "flag with entry", int'(sr_active), 1);
            break;
         end
      end
      chk("R9", "entry issued", int'(seen), 1);
      chk("R11", "only queued reads drained", npop, 2);
      @(negedge clk);
      host_req = 1'b1;
      #1 chk("R9", "ack while parked", int'(host_ack), 0);
      repeat (3) @(negedge clk);
      chk("R9", "cke stays low", int'(dram_cke), 0);
      chk("R9", "no command parked", int'(dram_cmd_vld), 0);
      sr_req = 1'b0;
      @(negedge clk);
      chk("R10", "exit cmd vld", int'(dram_cmd_vld), 1);
      chk("R10", "exit code", int'(dram_cmd), 7);
      chk("R10", "cke back", int'(dram_cke), 1);
      chk("R10", "flag cleared", int'(sr_active), 0);
      #1 chk("R10", "ack resumes", int'(host_ack), 1);
      @(negedge clk);
      host_req = 1'b0;
      @(negedge clk);
      chk("R10", "read after exit", int'(dram_cmd), 4);
      chk("R10", "read addr", int'(dram_addr), 'h3AA);

      // reset in the middle clears mode and clocks
      @(negedge clk);
      rst_n = 1'b0;
      #1 chk("R1", "clk_en async clear", int'(dram_clk_en), 0);
      chk("R1", "cke async clear", int'(dram_cke), 0);
      @(negedge clk);
      rst_n = 1'b1;
      do_access(0, 1'b0, 16'h0040);
      chk("R2", "clk_en after re-reset", int'(dram_clk_en), 0);

      summary();
      $finish;
   end

endmodule